// File: doc/BRIEF.md
# Size-Indexed Frame Allocator

This block hands out and takes back quad-aligned memory frames kept on free lists, one list per frame size index. The head word of each list lives in a table at a fixed base address, at offset equal to the size index. An allocation reads that head and decodes its two low tag bits. Depending on the tag, it takes the first frame from the list, follows a redirection to a different size class, or reports a frame fault. When it takes a frame, it unlinks it and fills in two overhead words of the new frame. A free pushes a frame back onto the front of its list.

Commands come in on a valid/ready interface and run one at a time. Each command ends with a single-cycle completion pulse. All table and frame traffic goes through one word-wide memory request port. That port uses valid/ready, and read data comes back on a separate return strobe. The caller keeps the table and the frames in memory that it owns, and handles the faults.

Top module: `frame_alloc`

## Requirements
- R1: After reset, cmd_ready is 1, and done, fault and mem_valid are 0.
- R2: The size index is masked to its low 8 bits. The list head for index i is the word at TABLE_BASE + i. Head tag bits [1:0] = 00 mean the head is the address of a free frame.
- R3: An allocation whose head has tag 00 does three things. It reads word 0 of that frame and writes that word into the head entry. It ends with done=1, fault=0 and frame_ptr equal to the old head value.
- R4: On a successful allocation, the return link is written at frame-3 and the global value at frame-2. The size word at frame-4 is never written.
- R5: A head with bit 0 = 1 means the list is empty. The allocation ends with done=1 and fault=1, and the table entry is left unchanged.
- R6: A head with tag 10 redirects the lookup. The alternate index is (head >> 2) masked to 8 bits, and the lookup repeats there. Only the head entry of the list the frame finally comes from is rewritten.
- R7: On any fault, fault_fsi equals the originally requested masked index, even after redirections.
- R8: Up to 8 redirections are followed. A 9th redirection ends the command with fault=1 and writes nothing.
- R9: A free masks the index, reads the current head, and writes it into word 0 of the freed frame. It then writes the frame address into the head entry, and ends with done=1 and fault=0.
- R10: cmd_ready is 1 only while no command is in progress. A command is accepted on a cycle where both cmd_valid and cmd_ready are 1.
- R11: done is a one-cycle pulse per command, and fault is 1 only together with done.
- R12: While mem_valid=1 and mem_ready=0, mem_addr, mem_write and mem_wdata stay unchanged. At most one read is outstanding, and the block waits for its mem_rvalid before issuing anything else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_free | input | 1 | 1 = free, 0 = allocate |
| cmd_fsi | input | W | Frame size index (low 8 bits used) |
| cmd_link | input | W | Return link stored on allocation |
| cmd_global | input | W | Global value stored on allocation |
| cmd_frame | input | W | Frame address to free |
| done | output | 1 | Command complete, one cycle |
| fault | output | 1 | Frame fault, valid with done |
| frame_ptr | output | W | Allocated frame, valid with done and no fault |
| fault_fsi | output | W | Original masked size index, valid with fault |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | W | Word address |
| mem_wdata | output | W | Write data |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | W | Read data |

## Verification
The assertions assume a memory that returns exactly one mem_rvalid for each accepted read, and never returns one on its own. They also assume every freed frame address is quad-aligned and every tag-00 head holds a quad-aligned address. Under those conditions the frame pointer reported on success is aligned. The bench meets these assumptions with a model that answers each accepted read one cycle later. It places frames only at addresses that are multiples of four, and it runs one allocation with mem_ready toggling every cycle to exercise back-pressure.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HEAD_RD,
    ST_HEAD_WT,
    ST_NEXT_RD,
    ST_NEXT_WT,
    ST_PUT_LINK,
    ST_PUT_GLOB,
    ST_PUT_HEAD,
    ST_PUT_W0
  } fa_state_e;

  typedef enum logic [1:0] {
    TAG_FRAME,
    TAG_EMPTY,
    TAG_ALT
  } fa_tag_e;
endpackage

// File: rtl/fa_head_decode.sv
module fa_head_decode
  import fa_pkg::*;
#(
  parameter int W     = 16,
  parameter int FSI_W = 8
) (
  input  logic [W-1:0] head,
  output fa_tag_e      tag,
  output logic [W-1:0] alt_fsi
);
  localparam logic [W-1:0] IDX_MASK = W'((1 << FSI_W) - 1);

  always_comb begin
    if (head[0])      tag = TAG_EMPTY;
    else if (head[1]) tag = TAG_ALT;
    else              tag = TAG_FRAME;
    alt_fsi = (head >> 2) & IDX_MASK;
  end
endmodule

// File: rtl/fa_redir_ctr.sv
module fa_redir_ctr #(
  parameter int MAX_REDIR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic limit_hit
);
  localparam int CW = $clog2(MAX_REDIR + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_REDIR);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (step)       cnt <= cnt + 1'b1;
  end

  assign limit_hit = (cnt == LIMIT);
endmodule

// File: rtl/frame_alloc.sv
module frame_alloc
  import fa_pkg::*;
#(
  parameter int            W          = 16,
  parameter int            FSI_W      = 8,
  parameter logic [15:0]   TABLE_BASE = 16'h0040,
  parameter int            MAX_REDIR  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_free,
  input  logic [W-1:0] cmd_fsi,
  input  logic [W-1:0] cmd_link,
  input  logic [W-1:0] cmd_global,
  input  logic [W-1:0] cmd_frame,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] frame_ptr,
  output logic [W-1:0] fault_fsi,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic         mem_write,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata
);
  localparam logic [W-1:0] IDX_MASK = W'((1 << FSI_W) - 1);
  localparam logic [W-1:0] BASE     = W'(TABLE_BASE);
  localparam logic [W-1:0] OFS_LINK = W'(3);
  localparam logic [W-1:0] OFS_GLOB = W'(2);

  fa_state_e    state;
  logic         op_free;
  logic [W-1:0] orig_idx, cur_idx, link_q, glob_q, frame_q, word_q;
  logic         done_q, fault_q;

  fa_tag_e      tag;
  logic [W-1:0] alt_idx;
  logic         ctr_clear, ctr_step, limit_hit;
  logic         accept, mem_fire;

  fa_head_decode #(.W(W), .FSI_W(FSI_W)) u_dec (
    .head    (mem_rdata),
    .tag     (tag),
    .alt_fsi (alt_idx)
  );

  fa_redir_ctr #(.MAX_REDIR(MAX_REDIR)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ctr_clear),
    .step      (ctr_step),
    .limit_hit (limit_hit)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign mem_fire  = mem_valid && mem_ready;
  assign ctr_clear = accept;
  assign ctr_step  = (state == ST_HEAD_WT) && mem_rvalid && !op_free &&
                     (tag == TAG_ALT) && !limit_hit;

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_HEAD_RD: begin
        mem_valid = 1'b1;
        mem_addr  = BASE + cur_idx;
      end
      ST_NEXT_RD: begin
        mem_valid = 1'b1;
        mem_addr  = frame_q;
      end
      ST_PUT_LINK: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = frame_q - OFS_LINK;
        mem_wdata = link_q;
      end
      ST_PUT_GLOB: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = frame_q - OFS_GLOB;
        mem_wdata = glob_q;
      end
      ST_PUT_HEAD: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = BASE + cur_idx;
        mem_wdata = op_free ? frame_q : word_q;
      end
      ST_PUT_W0: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = frame_q;
        mem_wdata = word_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_free  <= 1'b0;
      orig_idx <= '0;
      cur_idx  <= '0;
      link_q   <= '0;
      glob_q   <= '0;
      frame_q  <= '0;
      word_q   <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          op_free  <= cmd_free;
          orig_idx <= cmd_fsi & IDX_MASK;
          cur_idx  <= cmd_fsi & IDX_MASK;
          link_q   <= cmd_link;
          glob_q   <= cmd_global;
          frame_q  <= cmd_frame;
          state    <= ST_HEAD_RD;
        end
        ST_HEAD_RD: if (mem_fire) state <= ST_HEAD_WT;
        ST_HEAD_WT: if (mem_rvalid) begin
          if (op_free) begin
            word_q <= mem_rdata;
            state  <= ST_PUT_W0;
          end else begin
            unique case (tag)
              TAG_FRAME: begin
                frame_q <= mem_rdata;
                state   <= ST_NEXT_RD;
              end
              TAG_ALT: begin
                if (limit_hit) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b1;
                  state   <= ST_IDLE;
                end else begin
                  cur_idx <= alt_idx;
                  state   <= ST_HEAD_RD;
                end
              end
              default: begin
                done_q  <= 1'b1;
                fault_q <= 1'b1;
                state   <= ST_IDLE;
              end
            endcase
          end
        end
        ST_NEXT_RD: if (mem_fire) state <= ST_NEXT_WT;
        ST_NEXT_WT: if (mem_rvalid) begin
          word_q <= mem_rdata;
          state  <= ST_PUT_LINK;
        end
        ST_PUT_LINK: if (mem_fire) state <= ST_PUT_GLOB;
        ST_PUT_GLOB: if (mem_fire) state <= ST_PUT_HEAD;
        ST_PUT_W0:   if (mem_fire) state <= ST_PUT_HEAD;
        ST_PUT_HEAD: if (mem_fire) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign fault     = fault_q;
  assign frame_ptr = frame_q;
  assign fault_fsi = orig_idx;
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int W     = 16,
  parameter int FSI_W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [W-1:0] cmd_fsi,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] frame_ptr,
  input logic [W-1:0] fault_fsi,
  input logic         mem_valid,
  input logic         mem_ready,
  input logic         mem_write,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata
);
  localparam logic [W-1:0] IDX_MASK = W'((1 << FSI_W) - 1);

  logic [W-1:0] req_idx;
  always_ff @(posedge clk) begin
    if (!rst_n) req_idx <= '0;
    else if (cmd_valid && cmd_ready) req_idx <= cmd_fsi & IDX_MASK;
  end

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cmd_ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  assert_fault_param_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_fsi == req_idx));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  assert_frame_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (frame_ptr[1:0] == 2'b00));
endmodule

bind frame_alloc fa_checker #(.W(W), .FSI_W(FSI_W)) u_fa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_fsi   (cmd_fsi),
  .done      (done),
  .fault     (fault),
  .frame_ptr (frame_ptr),
  .fault_fsi (fault_fsi),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/tb_frame_alloc.sv
module tb_frame_alloc;
  localparam int W = 16;
  localparam int BASE = 'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         cmd_valid = 1'b0, cmd_free = 1'b0;
  logic         cmd_ready;
  logic [W-1:0] cmd_fsi = '0, cmd_link = '0, cmd_global = '0, cmd_frame = '0;
  logic         done, fault;
  logic [W-1:0] frame_ptr, fault_fsi;
  logic         mem_valid, mem_write;
  logic         mem_ready;
  logic [W-1:0] mem_addr, mem_wdata;
  logic         mem_rvalid;
  logic [W-1:0] mem_rdata;

  frame_alloc #(.W(W), .FSI_W(8), .TABLE_BASE(16'h0040), .MAX_REDIR(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_free(cmd_free), .cmd_fsi(cmd_fsi), .cmd_link(cmd_link),
    .cmd_global(cmd_global), .cmd_frame(cmd_frame), .done(done), .fault(fault),
    .frame_ptr(frame_ptr), .fault_fsi(fault_fsi), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: all array writes happen here
  logic [W-1:0] mem [0:1023];
  logic         stall = 1'b0;
  logic         pl_en = 1'b0;
  logic [9:0]   pl_addr = '0;
  logic [W-1:0] pl_data = '0;
  int           wr_count = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst_n) begin
      mem_ready <= 1'b1;
      mem_rdata <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else begin
      mem_ready <= stall ? ~mem_ready : 1'b1;
      if (pl_en) mem[pl_addr] <= pl_data;
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          mem[mem_addr[9:0]] <= mem_wdata;
          wr_count <= wr_count + 1;
        end else begin
          mem_rdata  <= mem[mem_addr[9:0]];
          mem_rvalid <= 1'b1;
        end
      end
    end
  end

  int checks = 0, fails = 0;
  logic         r_fault;
  logic [W-1:0] r_ptr, r_ffsi;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = 10'(a); pl_data = W'(d);
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic run_cmd(input logic fr, input int fsi, input int lnk, input int glb, input int frm);
    int guard;
    @(negedge clk);
    cmd_free = fr; cmd_fsi = W'(fsi); cmd_link = W'(lnk);
    cmd_global = W'(glb); cmd_frame = W'(frm); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 busy", {31'd0, cmd_ready}, 0);
    guard = 0;
    while (!done && guard < 500) begin @(negedge clk); guard++; end
    chk("R11 done seen", {31'd0, done}, 1);
    r_fault = fault; r_ptr = frame_ptr; r_ffsi = fault_fsi;
    @(negedge clk);
    chk("R11 single pulse", {30'd0, done, fault}, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, cmd_ready}, 1);
    chk("R1 done/fault/mem", {29'd0, done, fault, mem_valid}, 0);
  endtask

  task automatic t_alloc_basic;
    poke(BASE + 3, 'h200); poke('h200, 'h240); poke('h1FC, 'h1F);
    run_cmd(1'b0, 3, 'h1111, 'h2222, 0);
    chk("R3 no fault", {31'd0, r_fault}, 0);
    chk("R3 frame_ptr", r_ptr, 'h200);
    chk("R3 head updated", mem[BASE + 3], 'h240);
    chk("R4 link at -3", mem['h1FD], 'h1111);
    chk("R4 global at -2", mem['h1FE], 'h2222);
    chk("R4 size word kept", mem['h1FC], 'h1F);
  endtask

  task automatic t_empty;
    int w0;
    poke(BASE + 5, 'h0001);
    w0 = wr_count;
    run_cmd(1'b0, 5, 1, 2, 0);
    chk("R5 fault", {31'd0, r_fault}, 1);
    chk("R7 fault index", r_ffsi, 5);
    chk("R5 head unchanged", mem[BASE + 5], 'h0001);
    chk("R5 no writes", wr_count - w0, 0);
  endtask

  task automatic t_redirect;
    poke(BASE + 4, (7 << 2) | 2); poke(BASE + 7, 'h280); poke('h280, 'h0001);
    run_cmd(1'b0, 'h0104, 'h3333, 'h4444, 0);
    chk("R6 no fault", {31'd0, r_fault}, 0);
    chk("R6 frame", r_ptr, 'h280);
    chk("R6 alternate head", mem[BASE + 7], 'h0001);
    chk("R6 original head kept", mem[BASE + 4], (7 << 2) | 2);
    chk("R2 masked index link", mem['h27D], 'h3333);
    run_cmd(1'b0, 4, 0, 0, 0);
    chk("R7 fault after redirect", {31'd0, r_fault}, 1);
    chk("R7 original index", r_ffsi, 4);
  endtask

  task automatic t_limit;
    int w0;
    for (int i = 20; i < 28; i++) poke(BASE + i, ((i + 1) << 2) | 2);
    poke(BASE + 28, 'h2C0); poke('h2C0, 'h0001);
    run_cmd(1'b0, 20, 5, 6, 0);
    chk("R8 eight redirects ok", {31'd0, r_fault}, 0);
    chk("R8 frame", r_ptr, 'h2C0);
    for (int i = 30; i < 39; i++) poke(BASE + i, ((i + 1) << 2) | 2);
    poke(BASE + 39, 'h2E0);
    w0 = wr_count;
    run_cmd(1'b0, 30, 5, 6, 0);
    chk("R8 ninth redirect faults", {31'd0, r_fault}, 1);
    chk("R8 fault index", r_ffsi, 30);
    chk("R8 no writes", wr_count - w0, 0);
    chk("R8 end head kept", mem[BASE + 39], 'h2E0);
  endtask

  task automatic t_free_then_alloc;
    run_cmd(1'b1, 'h1F03, 0, 0, 'h300);
    chk("R9 no fault", {31'd0, r_fault}, 0);
    chk("R9 old head into word0", mem['h300], 'h240);
    chk("R9 head is frame", mem[BASE + 3], 'h300);
    stall = 1'b1;
    run_cmd(1'b0, 3, 'h5555, 'h6666, 0);
    stall = 1'b0;
    chk("R12 frame under backpressure", r_ptr, 'h300);
    chk("R12 head under backpressure", mem[BASE + 3], 'h240);
    chk("R12 link under backpressure", mem['h2FD], 'h5555);
    chk("R12 global under backpressure", mem['h2FE], 'h6666);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_alloc_basic();
    t_empty();
    t_redirect();
    t_limit();
    t_free_then_alloc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule